// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast system clock into the time base of a CAN bit engine. A programmable prescaler divides the system clock into time quanta. A segment sequencer then walks each bit through a one-quantum sync segment, a first phase segment (propagation plus phase 1) and a second phase segment. It marks the sample point at the end of the first segment and the bit boundary at the end of the second. The bus input is captured at the sample point, either as a single sample or as a majority vote over three consecutive system-clock samples.

Software programs a prescaler register and a timing register while `cfg_mode` is high. While `cfg_mode` is high the time base is parked at the start of a sync quantum. When it drops, bit timing runs freely. A falling-edge pulse from the bus edge detector either restarts the bit (hard sync, when `hard_sync_en` is high) or adjusts the current bit by up to the jump width (resynchronisation).

Top module: `can_bit_timer`

## Requirements
- R1: `presc_wdata` holds the prescaler minus one. `tq_tick` pulses once every prescaler system clocks. A stored value below 3 acts as 3, so a quantum is never shorter than 4 clocks.
- R2: Timing register bits 3:0 hold segment-one length minus one and bits 6:4 hold segment-two length minus one. A bit lasts prescaler × (1 + seg1 + seg2) clocks, and `bit_start` pulses on the tick that ends segment two.
- R3: `sample_stb` pulses on the tick that ends segment one, prescaler × (1 + seg1) clocks after the bit begins.
- R4: Writes to either register take effect only while `cfg_mode` is high. Writes made while it is low leave the bit timing unchanged.
- R5: While `cfg_mode` is high no strobe fires. After it falls, the first `tq_tick` is seen prescaler − 1 clock edges later and the first bit starts with its sync quantum.
- R6: With timing bit 7 clear, `rx_bit` takes the value of `rx_in` at the clock edge that closes the sample-strobe cycle, and holds it until the next sample.
- R7: With timing bit 7 set, `rx_bit` takes the majority of `rx_in` at that edge and at the two edges before it.
- R8: Timing bits 9:8 hold the jump width minus one. An edge in segment one, at quantum index q of that segment, lengthens segment one by min(jump width, q + 1).
- R9: An edge in segment two, at quantum index q of that segment, shortens segment two by min(jump width, seg2 − q − 1).
- R10: An edge with `hard_sync_en` high restarts the prescaler and the bit at the start of a sync quantum.
- R11: Without hard sync, an edge during the sync quantum has no effect. Only the first resynchronising edge in a bit acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode: enables writes and parks the time base |
| presc_wr | input | 1 | Write strobe for the prescaler register |
| presc_wdata | input | 10 | Prescaler minus one |
| tim_wr | input | 1 | Write strobe for the timing register |
| tim_wdata | input | 10 | Segment lengths, triple-sample enable, jump width |
| rx_in | input | 1 | Bus value (1 = recessive) |
| fall_edge | input | 1 | One-cycle pulse on a recessive-to-dominant bus edge |
| hard_sync_en | input | 1 | Treat `fall_edge` as a hard sync |
| tq_tick | output | 1 | Last system clock of each time quantum |
| bit_start | output | 1 | Last tick of a bit; the next bit starts after it |
| sample_stb | output | 1 | Sample-point tick |
| rx_bit | output | 1 | Bus value captured at the sample point |

## Verification
The hardest states to reach from the ports are resynchronisation edges that land in a chosen quantum of a chosen segment, including a second edge in the same bit. The expected shifts depend on both the quantum index and the jump-width limit. The stimulus counts clock edges from the release of configuration mode and places each one-cycle edge pulse at an exact, precomputed edge count inside the target quantum, never on a tick cycle. It then measures where the sample point and the next two bit boundaries land. The triple-sample vote is reached the same way: a one-clock glitch, or a two-clock dip, is placed on `rx_in` exactly at the edges around the sample point.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int T1_W   = 4;
  localparam int T2_W   = 3;
  localparam int SJW_W  = 2;
  localparam int TIM_W  = 10;
  localparam int QIDX_W = 5;
  localparam int EXT_W  = 3;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;

  // packed MSB first: matches the timing register layout 9:8, 7, 6:4, 3:0
  typedef struct packed {
    logic [SJW_W-1:0] sjw_m1;
    logic             triple;
    logic [T2_W-1:0]  t2_m1;
    logic [T1_W-1:0]  t1_m1;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_regs.sv
module can_bt_regs
  import can_bt_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int BRP_MIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic               presc_wr,
  input  logic [PRESC_W-1:0] presc_wdata,
  input  logic               tim_wr,
  input  logic [TIM_W-1:0]   tim_wdata,
  output logic [PRESC_W-1:0] brp_m1,
  output bt_cfg_t            cfg
);
  localparam logic [PRESC_W-1:0] BRP_FLOOR = PRESC_W'(BRP_MIN - 1);

  logic [PRESC_W-1:0] brp_q, brp_d;
  bt_cfg_t            cfg_q, cfg_d;
  logic               presc_en, tim_en;

  assign presc_en = cfg_mode && presc_wr;
  assign tim_en   = cfg_mode && tim_wr;

  always_comb begin
    brp_d = brp_q;
    cfg_d = cfg_q;
    if (presc_en) brp_d = presc_wdata;
    if (tim_en)   cfg_d = bt_cfg_t'(tim_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brp_q <= '0;
      cfg_q <= '0;
    end else begin
      brp_q <= brp_d;
      cfg_q <= cfg_d;
    end
  end

  assign brp_m1 = (brp_q < BRP_FLOOR) ? BRP_FLOOR : brp_q;
  assign cfg    = cfg_q;
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PRESC_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] brp_m1,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q, cnt_d;
  logic               wrap;

  assign wrap = (cnt_q >= brp_m1);
  assign tick = run && wrap;

  always_comb begin
    if (!run || restart) cnt_d = '0;
    else if (wrap)       cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    tick,
  input  logic    edge_in,
  input  logic    hsync,
  input  bt_cfg_t cfg,
  output logic    sample_stb,
  output logic    bit_start
);
  seg_e              seg_q, seg_d;
  logic [QIDX_W-1:0] qidx_q, qidx_d;
  logic [EXT_W-1:0]  ext_q, ext_d, cut_q, cut_d;
  logic              done_q, done_d;

  logic [EXT_W-1:0]  sjw;
  logic [QIDX_W-1:0] seg1_end, late;
  logic [T2_W-1:0]   seg2_end, rem_m1;
  logic              resync;

  assign sjw      = EXT_W'(cfg.sjw_m1) + 1'b1;
  assign seg1_end = QIDX_W'(cfg.t1_m1) + QIDX_W'(ext_q);
  assign seg2_end = cfg.t2_m1 - T2_W'(cut_q);
  assign late     = qidx_q + 1'b1;
  assign rem_m1   = cfg.t2_m1 - qidx_q[T2_W-1:0];
  assign resync   = edge_in && !hsync && !done_q;

  assign sample_stb = tick && (seg_q == SEG_ONE) && (qidx_q == seg1_end);
  assign bit_start  = tick && (seg_q == SEG_TWO) && (qidx_q == QIDX_W'(seg2_end));

  always_comb begin
    seg_d  = seg_q;
    qidx_d = qidx_q;
    ext_d  = ext_q;
    cut_d  = cut_q;
    done_d = done_q;
    if (!run || (edge_in && hsync)) begin
      seg_d  = SEG_SYNC;
      qidx_d = '0;
      ext_d  = '0;
      cut_d  = '0;
      done_d = 1'b0;
    end else begin
      if (resync && seg_q == SEG_ONE) begin
        ext_d  = (QIDX_W'(sjw) < late) ? sjw : EXT_W'(late);
        done_d = 1'b1;
      end
      if (resync && seg_q == SEG_TWO) begin
        cut_d  = (T2_W'(sjw) < rem_m1) ? sjw : EXT_W'(rem_m1);
        done_d = 1'b1;
      end
      if (tick) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d  = SEG_ONE;
            qidx_d = '0;
          end
          SEG_ONE: begin
            if (sample_stb) begin
              seg_d  = SEG_TWO;
              qidx_d = '0;
            end else qidx_d = qidx_q + 1'b1;
          end
          default: begin
            if (bit_start) begin
              seg_d  = SEG_SYNC;
              qidx_d = '0;
              ext_d  = '0;
              cut_d  = '0;
              done_d = 1'b0;
            end else qidx_d = qidx_q + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      qidx_q <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      qidx_q <= qidx_d;
      ext_q  <= ext_d;
      cut_q  <= cut_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic sample,
  input  logic triple,
  output logic rx_bit
);
  logic [1:0] hist_q, hist_d;
  logic       bit_q, bit_d, vote;

  assign vote = (rx_in & hist_q[0]) | (rx_in & hist_q[1]) | (hist_q[0] & hist_q[1]);

  always_comb begin
    hist_d = {hist_q[0], rx_in};
    bit_d  = bit_q;
    if (sample) bit_d = triple ? vote : rx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      bit_q  <= 1'b1;
    end else begin
      hist_q <= hist_d;
      bit_q  <= bit_d;
    end
  end

  assign rx_bit = bit_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int BRP_MIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic               presc_wr,
  input  logic [PRESC_W-1:0] presc_wdata,
  input  logic               tim_wr,
  input  logic [TIM_W-1:0]   tim_wdata,
  input  logic               rx_in,
  input  logic               fall_edge,
  input  logic               hard_sync_en,
  output logic               tq_tick,
  output logic               bit_start,
  output logic               sample_stb,
  output logic               rx_bit
);
  logic               rst_meta, rst_core;
  logic [PRESC_W-1:0] brp_m1;
  bt_cfg_t            cfg;
  logic               run, hs_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  assign run    = !cfg_mode;
  assign hs_now = fall_edge && hard_sync_en;

  can_bt_regs #(.PRESC_W(PRESC_W), .BRP_MIN(BRP_MIN)) u_regs (
    .clk(clk), .rst_n(rst_core), .cfg_mode(cfg_mode),
    .presc_wr(presc_wr), .presc_wdata(presc_wdata),
    .tim_wr(tim_wr), .tim_wdata(tim_wdata),
    .brp_m1(brp_m1), .cfg(cfg)
  );

  can_bt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_core), .run(run), .restart(hs_now),
    .brp_m1(brp_m1), .tick(tq_tick)
  );

  can_bt_seq u_seq (
    .clk(clk), .rst_n(rst_core), .run(run), .tick(tq_tick),
    .edge_in(fall_edge), .hsync(hard_sync_en), .cfg(cfg),
    .sample_stb(sample_stb), .bit_start(bit_start)
  );

  can_bt_sampler u_samp (
    .clk(clk), .rst_n(rst_core), .rx_in(rx_in), .sample(sample_stb),
    .triple(cfg.triple), .rx_bit(rx_bit)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk
  import can_bt_pkg::*;
#(
  parameter int PRESC_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_mode,
  input logic               tq_tick,
  input logic               bit_start,
  input logic               sample_stb,
  input logic               rx_bit,
  input logic [PRESC_W-1:0] brp_m1,
  input bt_cfg_t            cfg
);
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);

  a_r3_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> tq_tick);

  a_r2_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> tq_tick);

  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start));

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_stb) |-> $stable(rx_bit));

  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_mode) |-> ($stable(brp_m1) && $stable(cfg)));
endmodule

bind can_bit_timer can_bit_timer_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .tq_tick(tq_tick),
  .bit_start(bit_start), .sample_stb(sample_stb), .rx_bit(rx_bit),
  .brp_m1(brp_m1), .cfg(cfg)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
  logic       clk, rst_n, cfg_mode, presc_wr, tim_wr, rx_in, fall_edge, hard_sync_en;
  logic [9:0] presc_wdata, tim_wdata;
  logic       tq_tick, bit_start, sample_stb, rx_bit;
  int         tests, fails;

  can_bit_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .presc_wr(presc_wr),
    .presc_wdata(presc_wdata), .tim_wr(tim_wr), .tim_wdata(tim_wdata),
    .rx_in(rx_in), .fall_edge(fall_edge), .hard_sync_en(hard_sync_en),
    .tq_tick(tq_tick), .bit_start(bit_start), .sample_stb(sample_stb), .rx_bit(rx_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [9:0]  presc;
    logic [9:0]  tim;
    logic [15:0] ea;
    logic [15:0] eb;
    logic        hs;
    logic [15:0] s1;
    logic [15:0] b1;
    logic [15:0] b2;
  } vec_t;

  // edge counts are clock edges after cfg_mode falls; 0 = no edge pulse
  localparam vec_t VECS [10] = '{
    '{10'd3, 10'h012, 16'd0,  16'd0, 1'b0, 16'd15,  16'd23,  16'd47},  // R2 R3 base
    '{10'd0, 10'h012, 16'd0,  16'd0, 1'b0, 16'd15,  16'd23,  16'd47},  // R1 floor
    '{10'd9, 10'h07F, 16'd0,  16'd0, 1'b0, 16'd169, 16'd249, 16'd499}, // R2 max segs
    '{10'd4, 10'h000, 16'd0,  16'd0, 1'b0, 16'd9,   16'd14,  16'd29},  // R2 min segs
    '{10'd3, 10'h132, 16'd9,  16'd0, 1'b0, 16'd23,  16'd39,  16'd71},  // R8 lengthen
    '{10'd3, 10'h032, 16'd13, 16'd0, 1'b0, 16'd19,  16'd35,  16'd67},  // R8 jump limit
    '{10'd3, 10'h132, 16'd17, 16'd0, 1'b0, 16'd15,  16'd23,  16'd55},  // R9 shorten
    '{10'd3, 10'h132, 16'd1,  16'd0, 1'b0, 16'd15,  16'd31,  16'd63},  // R11 sync quantum
    '{10'd3, 10'h332, 16'd5,  16'd9, 1'b0, 16'd19,  16'd35,  16'd67},  // R11 second edge
    '{10'd3, 10'h012, 16'd9,  16'd0, 1'b1, 16'd25,  16'd33,  16'd57}   // R10 hard sync
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [9:0] p, input logic [9:0] t);
    @(negedge clk);
    cfg_mode = 1'b1; fall_edge = 1'b0; hard_sync_en = 1'b0;
    presc_wr = 1'b1; presc_wdata = p;
    @(negedge clk);
    presc_wr = 1'b0; tim_wr = 1'b1; tim_wdata = t;
    @(negedge clk);
    tim_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int ft, fs, fb1, fb2;
    ft = 0; fs = 0; fb1 = 0; fb2 = 0;
    setup(v.presc, v.tim);
    cfg_mode = 1'b0;
    for (int n = 1; n <= 600 && fb2 == 0; n++) begin
      @(negedge clk);
      if (tq_tick && ft == 0) ft = n;
      if (sample_stb && fs == 0) fs = n;
      if (bit_start) begin
        if (fb1 == 0) fb1 = n; else if (fb2 == 0) fb2 = n;
      end
      fall_edge    = (n == int'(v.ea)) || (n == int'(v.eb));
      hard_sync_en = v.hs;
    end
    fall_edge = 1'b0; hard_sync_en = 1'b0;
    $display("vector %0d", idx);
    chk("R1 R5 first tick", ft, ((v.presc < 10'd3) ? 3 : int'(v.presc)));
    chk("R3 sample point", fs, int'(v.s1));
    chk("R2 first bit end", fb1, int'(v.b1));
    chk("R2 second bit end", fb2, int'(v.b2));
  endtask

  task automatic rx_case(input logic [9:0] t, input bit two, input logic exp, input string req);
    setup(10'd3, t);
    cfg_mode = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      rx_in = !((n == 15) || (two && n == 14));
    end
    chk(req, rx_bit, exp);
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt, gap;
    tests = 0; fails = 0;
    rst_n = 1'b0; cfg_mode = 1'b1; presc_wr = 1'b0; tim_wr = 1'b0;
    presc_wdata = '0; tim_wdata = '0; rx_in = 1'b1; fall_edge = 1'b0; hard_sync_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("reset tick", tq_tick, 0);
    chk("reset sample", sample_stb, 0);
    chk("reset bit", bit_start, 0);
    chk("reset rx_bit", rx_bit, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: no strobes while parked in configuration mode
    cnt = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      cnt += int'(tq_tick) + int'(sample_stb) + int'(bit_start);
    end
    chk("R5 quiet in cfg", cnt, 0);

    for (int i = 0; i < 10; i++) run_vec(VECS[i], i);

    // R4: writes while running are ignored, bit period stays 24
    setup(10'd3, 10'h012);
    cfg_mode = 1'b0;
    @(negedge clk);
    presc_wr = 1'b1; presc_wdata = 10'd9; tim_wr = 1'b1; tim_wdata = 10'h07F;
    @(negedge clk);
    presc_wr = 1'b0; tim_wr = 1'b0;
    while (!bit_start) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!bit_start && gap < 400);
    chk("R4 write ignored", gap, 24);

    // R6, R7: sample point visible after edge 15, captured at edge 16
    rx_case(10'h012, 1'b0, 1'b0, "R6 single sample");
    rx_case(10'h092, 1'b0, 1'b1, "R7 glitch outvoted");
    rx_case(10'h092, 1'b1, 1'b0, "R7 two-of-three");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule